// File: doc/BRIEF.md
# Sector Erase-and-Verify Sequencer

This controller runs the complete erase of one sector of a multi-level NOR array. A start strobe latches the target sector. The controller then issues an erase pulse to the whole sector. It brings the charged source node down in two phases: a slow bleed until a comparator reports a safe level, followed by a timed fast discharge. Once the source is down, it walks the sector address by address and samples a per-cell verify result. If any cell is still programmed, another pulse follows at a source-level code one step higher than the previous one. Verification then picks up again at the failing address instead of returning to address zero.

When every cell verifies, a second walk looks for over-erased (depleted) cells. Each depleted cell receives soft-program pulses, each followed by a re-check, until it is no longer depleted or a retry limit is reached. The sequencer finishes with a done flag, or with a fail flag if the erase ladder or a soft-program repair runs out of attempts. The charge pumps, the analog sensing and the cell array are outside this block. They connect through the enables, the code and the result inputs.

Top module: `sector_erase_seq`

## Requirements
- R1: A one-cycle `start` while idle, done or failed latches `sector_sel` into `tgt_sector`, clears both flags, sets `src_lvl` to 0 and begins an erase pulse on the next cycle. `start` and changes on `sector_sel` during a run have no effect on the run's outcome or on `tgt_sector`.
- R2: Each erase pulse holds `erase_on` high for exactly PULSE_LEN (default 4) cycles. While it is high, `vfy_en`, `scan_en` and `soft_on` are low and `dis_mode` is 0.
- R3: The first pulse of a run uses `src_lvl` = 0. Each later pulse uses the previous code plus one, saturating at the all-ones code (7 by default).
- R4: After every pulse, `dis_mode` = 2'b01 (slow) is held until `safe_lvl` is sampled high. Then `dis_mode` = 2'b10 (fast) is held for FAST_LEN (default 3) cycles, and only after that does verify begin. `dis_mode` = 2'b00 means no discharge.
- R5: During verify, `vfy_en` is high and `cell_addr` presents one address per cycle, stepping up from 0 while `vfy_ok` is high. A pass at the last address (2^ADDR_W-1) starts the depletion scan.
- R6: If `vfy_ok` is low, another pulse is issued and verify restarts at the same address. A passing run therefore spends 2^ADDR_W + P - 1 verify cycles for P pulses.
- R7: If verify fails after TOP_PULSES (default 2) pulses have been issued at the maximum code, `fail` rises. With the defaults, 9 pulses is the most a run can issue.
- R8: During the depletion scan, `scan_en` is high and `cell_addr` steps from 0. A high `depl` starts a soft-program pulse (`soft_on` high for SP_LEN, default 2, cycles) followed by a one-cycle re-check with `scan_en` high. Repair repeats until `depl` is low, and then the scan continues.
- R9: If a cell still reads depleted after SP_RETRY (default 3) soft-program pulses, `fail` rises.
- R10: A clean scan of the last address raises `done`. `done` and `fail` are never high together. Each stays high, with all enables low, until the next `start`.
- R11: While `rst` is high, and in the cycle after it is released, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to erase the selected sector |
| sector_sel | input | SECT_W | Sector to erase, sampled with `start` |
| vfy_ok | input | 1 | Verify result for `cell_addr`: 1 = erased |
| depl | input | 1 | Depletion check result for `cell_addr`: 1 = depleted |
| safe_lvl | input | 1 | Source node has fallen below the safe level |
| erase_on | output | 1 | Erase pulse enable for the whole sector |
| src_lvl | output | LVL_W | Source voltage step code for the pulse |
| cell_addr | output | ADDR_W | Address being verified, scanned or repaired |
| vfy_en | output | 1 | Verify sensing active |
| scan_en | output | 1 | Depletion check active |
| soft_on | output | 1 | Soft-program pulse enable for `cell_addr` |
| dis_mode | output | 2 | Source discharge rate: 00 off, 01 slow, 10 fast |
| tgt_sector | output | SECT_W | Sector latched at start |
| done | output | 1 | Erase completed |
| fail | output | 1 | Erase or repair exhausted its attempts |

## Verification
The properties assume that `vfy_ok` and `depl` matter only in cycles where `vfy_en` or `scan_en` is high. They also assume that `safe_lvl` eventually rises while the slow discharge is held. The code-step and resume-address properties exclude cycles that follow a `start`, because a new run legitimately resets both. The stimulus comes from a behavioural cell model in the bench. It counts pulses seen, answers verify from a per-cell pulse requirement, reports depletion until a set number of soft-program pulses has arrived, and raises `safe_lvl` after three cycles of slow discharge. All inputs are driven on the falling edge from the outputs registered at the previous rising edge.

// File: rtl/ers_pkg.sv
package ers_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PULSE,
        ST_DSLOW,
        ST_DFAST,
        ST_VERIFY,
        ST_SCAN,
        ST_SOFT,
        ST_SCHK,
        ST_DONE,
        ST_FAIL
    } ers_state_e;

    typedef enum logic [1:0] {
        DIS_OFF  = 2'b00,
        DIS_SLOW = 2'b01,
        DIS_FAST = 2'b10
    } dis_mode_e;

    typedef struct packed {
        logic      erase_on;
        logic      vfy_en;
        logic      scan_en;
        logic      soft_on;
        dis_mode_e dis;
        logic      done;
        logic      fail;
    } ers_drive_t;

    function automatic ers_drive_t drive_of(ers_state_e s);
        ers_drive_t d;
        d = '{erase_on: 1'b0, vfy_en: 1'b0, scan_en: 1'b0, soft_on: 1'b0,
              dis: DIS_OFF, done: 1'b0, fail: 1'b0};
        case (s)
            ST_PULSE:  d.erase_on = 1'b1;
            ST_DSLOW:  d.dis      = DIS_SLOW;
            ST_DFAST:  d.dis      = DIS_FAST;
            ST_VERIFY: d.vfy_en   = 1'b1;
            ST_SCAN:   d.scan_en  = 1'b1;
            ST_SOFT:   d.soft_on  = 1'b1;
            ST_SCHK:   d.scan_en  = 1'b1;
            ST_DONE:   d.done     = 1'b1;
            ST_FAIL:   d.fail     = 1'b1;
            default:   ;
        endcase
        return d;
    endfunction

    function automatic int max_of(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ers_timer.sv
module ers_timer #(
    parameter int TW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expired
);
    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/ers_addr_ctr.sv
module ers_addr_ctr #(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              adv,
    output logic [ADDR_W-1:0] addr,
    output logic              at_last
);
    localparam logic [ADDR_W-1:0] LAST = '1;

    always_ff @(posedge clk) begin
        if (rst || clear)
            addr <= '0;
        else if (adv && addr != LAST)
            addr <= addr + 1'b1;
    end

    assign at_last = (addr == LAST);
endmodule

// File: rtl/ers_level_ctl.sv
module ers_level_ctl #(
    parameter int LVL_W      = 3,
    parameter int TOP_PULSES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             bump,
    input  logic             pulse_end,
    output logic [LVL_W-1:0] code,
    output logic             top_spent
);
    localparam logic [LVL_W-1:0] CODE_MAX = '1;
    localparam int               TCW      = $clog2(TOP_PULSES + 1);
    localparam logic [TCW-1:0]   TOP_LIM  = TCW'(TOP_PULSES);

    logic [TCW-1:0] top_cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear)
            code <= '0;
        else if (bump && code != CODE_MAX)
            code <= code + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || clear)
            top_cnt_q <= '0;
        else if (pulse_end && code == CODE_MAX && top_cnt_q != TOP_LIM)
            top_cnt_q <= top_cnt_q + 1'b1;
    end

    assign top_spent = (top_cnt_q == TOP_LIM);
endmodule

// File: rtl/sector_erase_seq.sv
module sector_erase_seq
    import ers_pkg::*;
#(
    parameter int SECT_W     = 3,
    parameter int ADDR_W     = 4,
    parameter int LVL_W      = 3,
    parameter int PULSE_LEN  = 4,
    parameter int FAST_LEN   = 3,
    parameter int TOP_PULSES = 2,
    parameter int SP_LEN     = 2,
    parameter int SP_RETRY   = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [SECT_W-1:0] sector_sel,
    input  logic              vfy_ok,
    input  logic              depl,
    input  logic              safe_lvl,
    output logic              erase_on,
    output logic [LVL_W-1:0]  src_lvl,
    output logic [ADDR_W-1:0] cell_addr,
    output logic              vfy_en,
    output logic              scan_en,
    output logic              soft_on,
    output logic [1:0]        dis_mode,
    output logic [SECT_W-1:0] tgt_sector,
    output logic              done,
    output logic              fail
);
    localparam int             TMAX   = max_of(max_of(PULSE_LEN, FAST_LEN), SP_LEN);
    localparam int             TW     = $clog2(TMAX + 1);
    localparam int             RW     = $clog2(SP_RETRY + 1);
    localparam logic [TW-1:0]  T_PULSE = TW'(PULSE_LEN - 1);
    localparam logic [TW-1:0]  T_FAST  = TW'(FAST_LEN - 1);
    localparam logic [TW-1:0]  T_SOFT  = TW'(SP_LEN - 1);
    localparam logic [RW-1:0]  R_LIM   = RW'(SP_RETRY);

    ers_state_e        state_q, state_n;
    logic [RW-1:0]     retry_q;
    logic              retry_first, retry_inc;
    logic              tmr_load, tmr_exp;
    logic [TW-1:0]     tmr_val;
    logic              addr_clr, addr_adv, addr_last;
    logic              lvl_clr, lvl_bump, pulse_end, top_spent;
    logic              take_start;
    ers_drive_t        drv;

    ers_timer #(.TW(TW)) u_timer (
        .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .expired(tmr_exp)
    );

    ers_addr_ctr #(.ADDR_W(ADDR_W)) u_addr (
        .clk(clk), .rst(rst), .clear(addr_clr), .adv(addr_adv),
        .addr(cell_addr), .at_last(addr_last)
    );

    ers_level_ctl #(.LVL_W(LVL_W), .TOP_PULSES(TOP_PULSES)) u_level (
        .clk(clk), .rst(rst), .clear(lvl_clr), .bump(lvl_bump),
        .pulse_end(pulse_end), .code(src_lvl), .top_spent(top_spent)
    );

    assign take_start = start &&
        (state_q == ST_IDLE || state_q == ST_DONE || state_q == ST_FAIL);

    always_comb begin
        state_n     = state_q;
        tmr_load    = 1'b0;
        tmr_val     = '0;
        addr_clr    = 1'b0;
        addr_adv    = 1'b0;
        lvl_clr     = 1'b0;
        lvl_bump    = 1'b0;
        pulse_end   = 1'b0;
        retry_first = 1'b0;
        retry_inc   = 1'b0;
        case (state_q)
            ST_IDLE, ST_DONE, ST_FAIL: begin
                if (take_start) begin
                    state_n  = ST_PULSE;
                    tmr_load = 1'b1;
                    tmr_val  = T_PULSE;
                    addr_clr = 1'b1;
                    lvl_clr  = 1'b1;
                end
            end
            ST_PULSE: begin
                if (tmr_exp) begin
                    state_n   = ST_DSLOW;
                    pulse_end = 1'b1;
                end
            end
            ST_DSLOW: begin
                if (safe_lvl) begin
                    state_n  = ST_DFAST;
                    tmr_load = 1'b1;
                    tmr_val  = T_FAST;
                end
            end
            ST_DFAST: begin
                if (tmr_exp)
                    state_n = ST_VERIFY;
            end
            ST_VERIFY: begin
                if (vfy_ok) begin
                    if (addr_last) begin
                        state_n  = ST_SCAN;
                        addr_clr = 1'b1;
                    end else begin
                        addr_adv = 1'b1;
                    end
                end else if (top_spent) begin
                    state_n = ST_FAIL;
                end else begin
                    state_n  = ST_PULSE;
                    tmr_load = 1'b1;
                    tmr_val  = T_PULSE;
                    lvl_bump = 1'b1;
                end
            end
            ST_SCAN: begin
                if (depl) begin
                    state_n     = ST_SOFT;
                    tmr_load    = 1'b1;
                    tmr_val     = T_SOFT;
                    retry_first = 1'b1;
                end else if (addr_last) begin
                    state_n = ST_DONE;
                end else begin
                    addr_adv = 1'b1;
                end
            end
            ST_SOFT: begin
                if (tmr_exp)
                    state_n = ST_SCHK;
            end
            ST_SCHK: begin
                if (!depl) begin
                    state_n = ST_SCAN;
                end else if (retry_q == R_LIM) begin
                    state_n = ST_FAIL;
                end else begin
                    state_n   = ST_SOFT;
                    tmr_load  = 1'b1;
                    tmr_val   = T_SOFT;
                    retry_inc = 1'b1;
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= ST_IDLE;
        else
            state_q <= state_n;
    end

    always_ff @(posedge clk) begin
        if (rst)
            retry_q <= '0;
        else if (retry_first)
            retry_q <= RW'(1);
        else if (retry_inc)
            retry_q <= retry_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            tgt_sector <= '0;
        else if (take_start)
            tgt_sector <= sector_sel;
    end

    assign drv      = drive_of(state_q);
    assign erase_on = drv.erase_on;
    assign vfy_en   = drv.vfy_en;
    assign scan_en  = drv.scan_en;
    assign soft_on  = drv.soft_on;
    assign dis_mode = drv.dis;
    assign done     = drv.done;
    assign fail     = drv.fail;
endmodule

// File: rtl/sector_erase_seq_chk.sv
module sector_erase_seq_chk #(
    parameter int SECT_W = 3,
    parameter int ADDR_W = 4,
    parameter int LVL_W  = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              erase_on,
    input logic [LVL_W-1:0]  src_lvl,
    input logic [ADDR_W-1:0] cell_addr,
    input logic              vfy_en,
    input logic              scan_en,
    input logic              soft_on,
    input logic [1:0]        dis_mode,
    input logic [SECT_W-1:0] tgt_sector,
    input logic              done,
    input logic              fail
);
    localparam logic [LVL_W-1:0] CMAX = '1;

    AST_PULSE_ALONE: assert property (@(posedge clk) disable iff (rst)
        erase_on |-> (!vfy_en && !scan_en && !soft_on && dis_mode == 2'b00)); // R2

    AST_CODE_STEP: assert property (@(posedge clk) disable iff (rst)
        ($rose(erase_on) && !$past(start)) |->
        (src_lvl == (($past(src_lvl) == CMAX) ? CMAX : LVL_W'($past(src_lvl) + 1'b1)))); // R3

    AST_FAST_AFTER_SLOW: assert property (@(posedge clk) disable iff (rst)
        (dis_mode == 2'b10 && $past(dis_mode) != 2'b10) |-> ($past(dis_mode) == 2'b01)); // R4

    AST_RESUME_ADDR: assert property (@(posedge clk) disable iff (rst)
        ($rose(erase_on) && !$past(start)) |-> $stable(cell_addr)); // R6

    AST_SOFT_FROM_SCAN: assert property (@(posedge clk) disable iff (rst)
        $rose(soft_on) |-> $past(scan_en)); // R8

    AST_SECTOR_HELD: assert property (@(posedge clk) disable iff (rst)
        !$past(start) |-> $stable(tgt_sector)); // R1

    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(done && fail)); // R10

    AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (rst)
        (fail && !start) |=> fail); // R10
endmodule

bind sector_erase_seq sector_erase_seq_chk #(
    .SECT_W(SECT_W), .ADDR_W(ADDR_W), .LVL_W(LVL_W)
) u_chk (
    .clk(clk), .rst(rst), .start(start), .erase_on(erase_on), .src_lvl(src_lvl),
    .cell_addr(cell_addr), .vfy_en(vfy_en), .scan_en(scan_en), .soft_on(soft_on),
    .dis_mode(dis_mode), .tgt_sector(tgt_sector), .done(done), .fail(fail)
);

// File: tb/sector_erase_seq_test.sv
module sector_erase_seq_test;
    localparam int SECT_W = 3, ADDR_W = 4, LVL_W = 3;
    localparam int PULSE_LEN = 4, FAST_LEN = 3, TOP_PULSES = 2, SP_LEN = 2, SP_RETRY = 3;
    localparam int NCELL = 1 << ADDR_W;
    localparam int CMAX = (1 << LVL_W) - 1;
    localparam int PMAX = CMAX + TOP_PULSES;
    localparam int SLOW_NEED = 3;

    // each entry: {base need, hot address, hot need, depleted address, soft pulses needed}
    localparam logic [39:0] VEC [8] = '{
        {8'd1, 8'd0,  8'd1,  8'd0,  8'd0},
        {8'd2, 8'd7,  8'd4,  8'd0,  8'd0},
        {8'd1, 8'd15, 8'd9,  8'd0,  8'd0},
        {8'd1, 8'd3,  8'd10, 8'd0,  8'd0},
        {8'd1, 8'd2,  8'd3,  8'd6,  8'd2},
        {8'd1, 8'd0,  8'd1,  8'd15, 8'd3},
        {8'd1, 8'd0,  8'd1,  8'd0,  8'd4},
        {8'd3, 8'd9,  8'd8,  8'd9,  8'd1}
    };

    logic clk = 1'b0, rst = 1'b1, start = 1'b0;
    logic [SECT_W-1:0] sector_sel = '0;
    logic vfy_ok = 1'b0, depl = 1'b0, safe_lvl = 1'b0;
    logic erase_on, vfy_en, scan_en, soft_on, done, fail;
    logic [LVL_W-1:0] src_lvl;
    logic [ADDR_W-1:0] cell_addr;
    logic [1:0] dis_mode;
    logic [SECT_W-1:0] tgt_sector;

    int checks = 0, errors = 0;
    int m_b = 1, m_h = 0, m_n = 1, m_d = 0, m_k = 0;
    int pulses, slow_c, fast_c, vfy_c, sp_c, er_c, soft_c, code_err, slow_run;
    logic prev_er = 1'b0, prev_sp = 1'b0;

    always #2 clk = ~clk;

    sector_erase_seq #(
        .SECT_W(SECT_W), .ADDR_W(ADDR_W), .LVL_W(LVL_W), .PULSE_LEN(PULSE_LEN),
        .FAST_LEN(FAST_LEN), .TOP_PULSES(TOP_PULSES), .SP_LEN(SP_LEN), .SP_RETRY(SP_RETRY)
    ) uut (
        .clk(clk), .rst(rst), .start(start), .sector_sel(sector_sel), .vfy_ok(vfy_ok),
        .depl(depl), .safe_lvl(safe_lvl), .erase_on(erase_on), .src_lvl(src_lvl),
        .cell_addr(cell_addr), .vfy_en(vfy_en), .scan_en(scan_en), .soft_on(soft_on),
        .dis_mode(dis_mode), .tgt_sector(tgt_sector), .done(done), .fail(fail)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int need_of(int a);
        return (a == m_h) ? m_n : m_b;
    endfunction

    // behavioural cell and source model, updated on the falling edge
    initial begin
        forever begin
            @(negedge clk);
            if (erase_on && !prev_er) begin
                pulses++;
                if (int'(src_lvl) != ((pulses - 1 > CMAX) ? CMAX : pulses - 1)) code_err++;
                slow_run = 0;
            end
            if (erase_on) er_c++;
            if (dis_mode == 2'b01) begin slow_c++; slow_run++; end
            if (dis_mode == 2'b10) fast_c++;
            if (vfy_en) vfy_c++;
            if (soft_on) soft_c++;
            if (soft_on && !prev_sp) sp_c++;
            prev_er = erase_on;
            prev_sp = soft_on;
            vfy_ok   = (pulses >= need_of(int'(cell_addr)));
            depl     = (m_k > 0) && (int'(cell_addr) == m_d) && (sp_c < m_k);
            safe_lvl = (slow_run >= SLOW_NEED);
        end
    end

    task automatic clear_model();
        pulses = 0; slow_c = 0; fast_c = 0; vfy_c = 0; sp_c = 0;
        er_c = 0; soft_c = 0; code_err = 0; slow_run = 0;
    endtask

    task automatic pulse_start(input logic [SECT_W-1:0] s);
        @(negedge clk);
        sector_sel = s;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_end(input int limit);
        int n = 0;
        while (!(done || fail) && n < limit) begin
            @(negedge clk);
            n++;
        end
        if (!(done || fail)) begin
            checks++; errors++;
            $display("FAIL watchdog R10 actual=%0d expected=%0d", n, -1);
        end
    endtask

    task automatic run_case(input logic [39:0] v, input logic [SECT_W-1:0] s, input bit poke);
        int ep, exp_fail, exp_sp, exp_vfy;
        m_b = int'(v[39:32]); m_h = int'(v[31:24]); m_n = int'(v[23:16]);
        m_d = int'(v[15:8]);  m_k = int'(v[7:0]);
        clear_model();
        pulse_start(s);
        if (poke) begin
            repeat (20) @(negedge clk);
            sector_sel = ~s;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        wait_end(5000);
        ep       = (m_n > PMAX) ? PMAX : m_n;
        exp_fail = (m_n > PMAX || m_k > SP_RETRY) ? 1 : 0;
        exp_sp   = (m_n > PMAX) ? 0 : ((m_k > SP_RETRY) ? SP_RETRY : m_k);
        exp_vfy  = (m_n > PMAX) ? (m_h + PMAX) : (NCELL + ep - 1);
        chk("R7 fail flag", int'(fail), exp_fail);
        chk("R10 done flag", int'(done), 1 - exp_fail);
        chk("R10 idle enables", int'({erase_on, vfy_en, scan_en, soft_on, dis_mode}), 0);
        chk("R3 pulse count", pulses, ep);
        chk("R3 code per pulse", code_err, 0);
        chk("R3 final code", int'(src_lvl), (ep - 1 > CMAX) ? CMAX : ep - 1);
        chk("R2 pulse width", er_c, PULSE_LEN * ep);
        chk("R4 slow cycles", slow_c, SLOW_NEED * ep);
        chk("R4 fast cycles", fast_c, FAST_LEN * ep);
        chk("R5 R6 verify cycles", vfy_c, exp_vfy);
        chk("R8 R9 soft pulses", sp_c, exp_sp);
        chk("R8 soft width", soft_c, SP_LEN * exp_sp);
        chk("R1 sector latch", int'(tgt_sector), int'(s));
    endtask

    initial begin
        int wd = 0;
        forever begin
            @(posedge clk);
            wd++;
            if (wd > 150000) begin
                errors++;
                $display("FAIL watchdog global actual=%0d expected=%0d", wd, 150000);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        clear_model();
        repeat (3) @(negedge clk);
        chk("R11 reset outputs", int'({erase_on, vfy_en, scan_en, soft_on, dis_mode,
                                      done, fail, src_lvl, cell_addr, tgt_sector}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R11 after release", int'({erase_on, done, fail, src_lvl, tgt_sector}), 0);

        for (int i = 0; i < 8; i++)
            run_case(VEC[i], SECT_W'(i), 1'b0);

        // directed: start and sector change during a run are ignored (R1)
        run_case(VEC[1], 3'd5, 1'b1);

        // directed: a new start after fail clears the flag and reruns (R1, R10)
        run_case(VEC[3], 3'd2, 1'b0);
        run_case(VEC[0], 3'd6, 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule